// File: doc/BRIEF.md
# Overlapping Segment Prefetch Controller

This controller streams a grey-scale image from external memory into two on-chip buffer banks, one segment at a time, so that a window filter downstream can read one bank while the other is being filled. External memory returns 32-bit words, each carrying four packed 8-bit pixels. The controller issues the word addresses, writes each returned word unchanged into the selected bank at consecutive addresses, and announces each finished segment together with the bank it sits in, its first image row and its row count.

Consecutive segments overlap by the kernel height minus one rows. Each new segment restarts the external address at the first row that a pending window still needs. Every window row set therefore lies wholly inside one bank. The final segment of a frame may be shorter than the nominal segment height. Banks alternate between the filling and the reading role. The controller never writes into a bank until the reader has released it, and it waits rather than overwriting.

The controller has four states. `ST_IDLE` waits for a start pulse. `ST_WAIT` holds until the bank due for filling is free. `ST_FILL` issues requests and writes returned words. `ST_SWAP` lasts one cycle, in which the segment is announced and the bank pointer flips. Transitions: IDLE→WAIT on start; WAIT→FILL when the target bank is free; FILL→SWAP when the last word of the segment is written; SWAP→WAIT when more rows remain, SWAP→IDLE after the final segment.

Top module: `seg_prefetch`

## Requirements
- R1: After reset the controller is idle: `ext_req`, `bank_we`, `seg_ready` and `frame_done` are all low.
- R2: A `start` pulse while idle begins a frame whose first segment starts at image row 0 (external word 0). A `start` while a frame is in progress has no effect on the address sequence.
- R3: Within a segment beginning at row r0, the k-th accepted request carries word address r0*IMG_W/4 + k. The k-th returned word is written unchanged to bank address k. A request is accepted in a cycle where `ext_req` and `ext_ready` are both high. Each response arrives with `ext_rvalid`, in request order.
- R4: A segment spans min(SEG_ROWS, IMG_H − r0) rows. That is nrows*IMG_W/4 words, after which no further request is issued for it.
- R5: The next segment starts at row r0 + SEG_ROWS − KER + 1.
- R6: One cycle after the last word of a segment is written, `seg_ready` pulses for exactly one cycle. During that cycle `seg_bank`, `seg_row0` and `seg_nrows` describe the finished segment.
- R7: Segments are written to banks 0,1,0,1,… counted from reset and continuing across frames (`bank_sel` 0 selects bank 0).
- R8: While the bank due for filling still holds an unreleased segment, the controller issues no request and no bank write.
- R9: A `release` pulse frees the oldest announced, unreleased segment's bank. A `release` when no bank holds a segment is ignored.
- R10: `frame_done` pulses together with the `seg_ready` of the segment that ends at row IMG_H. The controller then returns to idle and accepts a new `start`.
- R11: A request not accepted keeps `ext_req` high and `ext_addr` unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (honoured only when idle) |
| release_seg | input | 1 | Reader has drained its oldest bank |
| ext_req | output | 1 | External read request |
| ext_addr | output | EAW | External word address |
| ext_ready | input | 1 | External memory accepts the request |
| ext_rvalid | input | 1 | Returned word valid |
| ext_rdata | input | 32 | Returned word, four packed pixels |
| bank_we | output | 1 | Bank write strobe |
| bank_sel | output | 1 | Bank being written |
| bank_waddr | output | BAW | Word address inside the bank |
| bank_wdata | output | 32 | Word written into the bank |
| seg_ready | output | 1 | Segment finished pulse |
| seg_bank | output | 1 | Bank holding the finished segment |
| seg_row0 | output | RW | First image row of the finished segment |
| seg_nrows | output | RW | Rows in the finished segment |
| frame_done | output | 1 | Final segment of the frame finished |

## Verification
The bench sweeps two full frames of a small image with a random accept pattern. It checks every address, bank write and announcement against row arithmetic. A restart that continued linearly instead of stepping back KER−1 rows would show up on the first address of the second segment. A segment count that ignored the image bottom would overrun on the short last segment. The bench holds back releases until both banks are full, and a controller that overwrote a held bank would emit a request during that window. A spurious release before the first start, and a second start mid-frame, would corrupt the bank order or restart the addresses if either were wrongly honoured.

// File: rtl/seg_prefetch_pkg.sv
package seg_prefetch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_FILL,
        ST_SWAP
    } pf_state_t;

endpackage

// File: rtl/seg_sched.sv
module seg_sched #(
    parameter int IMG_H    = 128,
    parameter int SEG_ROWS = 32,
    parameter int KER      = 7,
    parameter int WPR      = 32,
    parameter int RW       = 8,
    parameter int CW       = 11,
    parameter int EAW      = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           advance,
    output logic [RW-1:0]  row0,
    output logic [RW-1:0]  nrows,
    output logic [CW-1:0]  words,
    output logic [EAW-1:0] base,
    output logic           last
);
    localparam int STEP = SEG_ROWS - KER + 1;

    logic [RW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            row0 <= '0;
        end else if (advance && !last) begin
            row0 <= row0 + RW'(STEP);
        end
    end

    always_comb begin
        remain = RW'(IMG_H) - row0;
        last   = (remain <= RW'(SEG_ROWS));
        nrows  = last ? remain : RW'(SEG_ROWS);
        words  = CW'(32'(nrows) * WPR);
        base   = EAW'(32'(row0) * WPR);
    end

    // R4
    segment_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nrows != '0) && (nrows <= RW'(SEG_ROWS)));

    // R5
    restart_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !last && !restart) |=> (row0 == $past(row0) + RW'(STEP)));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int CW  = 11,
    parameter int BAW = 10,
    parameter int EAW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           ext_ready,
    input  logic           ext_rvalid,
    input  logic [EAW-1:0] base,
    input  logic [CW-1:0]  words,
    output logic           ext_req,
    output logic [EAW-1:0] ext_addr,
    output logic           we,
    output logic [BAW-1:0] waddr,
    output logic           fill_end
);
    logic [CW-1:0]  req_cnt;
    logic [BAW-1:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            req_cnt <= '0;
        end else if (ext_req && ext_ready) begin
            req_cnt <= req_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            wr_cnt <= '0;
        end else if (we) begin
            wr_cnt <= wr_cnt + BAW'(1);
        end
    end

    always_comb begin
        ext_req  = run && (req_cnt < words);
        ext_addr = base + EAW'(req_cnt);
        we       = run && ext_rvalid;
        waddr    = wr_cnt;
        fill_end = we && ((CW'(wr_cnt) + CW'(1)) == words);
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ready) |=> (ext_req && $stable(ext_addr)));
endmodule

// File: rtl/seg_bank_arb.sv
module seg_bank_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic       release_seg,
    output logic       fill_bank,
    output logic       fill_blocked,
    output logic [1:0] full
);
    logic rd_ptr;
    logic rel_ok;

    assign rel_ok       = release_seg && full[rd_ptr];
    assign fill_blocked = full[fill_bank];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_bank <= 1'b0;
            rd_ptr    <= 1'b0;
        end else begin
            if (commit) fill_bank <= ~fill_bank;
            if (rel_ok) rd_ptr    <= ~rd_ptr;
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full[b] <= 1'b0;
            end else if (commit && (fill_bank == 1'(b))) begin
                full[b] <= 1'b1;
            end else if (rel_ok && (rd_ptr == 1'(b))) begin
                full[b] <= 1'b0;
            end
        end
    end

    // R8
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !full[fill_bank]);

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_seg && (full == 2'b00) && !commit) |=> (full == 2'b00));
endmodule

// File: rtl/seg_prefetch.sv
module seg_prefetch
    import seg_prefetch_pkg::*;
#(
    parameter int IMG_W    = 128,
    parameter int IMG_H    = 128,
    parameter int KER      = 7,
    parameter int SEG_ROWS = 32,
    parameter int PIX_W    = 8,
    parameter int PACK     = 4,
    localparam int WORD_W  = PIX_W * PACK,
    localparam int WPR     = IMG_W / PACK,
    localparam int SEG_WDS = SEG_ROWS * WPR,
    localparam int EAW     = $clog2(IMG_H * WPR),
    localparam int BAW     = $clog2(SEG_WDS),
    localparam int CW      = $clog2(SEG_WDS + 1),
    localparam int RW      = $clog2(IMG_H + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              release_seg,
    output logic              ext_req,
    output logic [EAW-1:0]    ext_addr,
    input  logic              ext_ready,
    input  logic              ext_rvalid,
    input  logic [WORD_W-1:0] ext_rdata,
    output logic              bank_we,
    output logic              bank_sel,
    output logic [BAW-1:0]    bank_waddr,
    output logic [WORD_W-1:0] bank_wdata,
    output logic              seg_ready,
    output logic              seg_bank,
    output logic [RW-1:0]     seg_row0,
    output logic [RW-1:0]     seg_nrows,
    output logic              frame_done
);
    pf_state_t state, state_nx;

    logic           run, commit, restart;
    logic           fill_end, fill_bank, fill_blocked, last;
    logic [1:0]     full;
    logic [CW-1:0]  words;
    logic [EAW-1:0] base;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)         state_nx = ST_WAIT;
            ST_WAIT: if (!fill_blocked) state_nx = ST_FILL;
            ST_FILL: if (fill_end)      state_nx = ST_SWAP;
            ST_SWAP: state_nx = last ? ST_IDLE : ST_WAIT;
        endcase
    end

    always_comb begin
        run        = 1'b0;
        commit     = 1'b0;
        restart    = 1'b0;
        frame_done = 1'b0;
        unique case (state)
            ST_IDLE: restart = start;
            ST_WAIT: ;
            ST_FILL: run = 1'b1;
            ST_SWAP: begin
                commit     = 1'b1;
                frame_done = last;
            end
        endcase
        seg_ready  = commit;
        seg_bank   = fill_bank;
        bank_sel   = fill_bank;
        bank_wdata = ext_rdata;
    end

    seg_sched #(
        .IMG_H(IMG_H), .SEG_ROWS(SEG_ROWS), .KER(KER), .WPR(WPR),
        .RW(RW), .CW(CW), .EAW(EAW)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(commit),
        .row0(seg_row0), .nrows(seg_nrows), .words(words), .base(base),
        .last(last)
    );

    seg_addr_gen #(.CW(CW), .BAW(BAW), .EAW(EAW)) u_addr (
        .clk(clk), .rst_n(rst_n), .run(run), .ext_ready(ext_ready),
        .ext_rvalid(ext_rvalid), .base(base), .words(words),
        .ext_req(ext_req), .ext_addr(ext_addr), .we(bank_we),
        .waddr(bank_waddr), .fill_end(fill_end)
    );

    seg_bank_arb u_arb (
        .clk(clk), .rst_n(rst_n), .commit(commit), .release_seg(release_seg),
        .fill_bank(fill_bank), .fill_blocked(fill_blocked), .full(full)
    );

    // R8
    held_bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req || bank_we) |-> !full[bank_sel]);

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_ready |=> !seg_ready);

    // R10
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (seg_ready && ((seg_row0 + seg_nrows) == RW'(IMG_H))));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!ext_req && !bank_we && !seg_ready));
endmodule

// File: tb/seg_prefetch_tb.sv
module seg_prefetch_tb;
    localparam int IMG_W = 16, IMG_H = 20, KER = 3, SEG_ROWS = 6;
    localparam int WPR = IMG_W / 4;
    localparam int STEP = SEG_ROWS - KER + 1;
    localparam int EAW = $clog2(IMG_H * WPR);
    localparam int BAW = $clog2(SEG_ROWS * WPR);
    localparam int RW  = $clog2(IMG_H + 1);

    logic clk = 0, rst_n = 0, start = 0, release_seg = 0;
    logic ext_req, ext_ready = 0, ext_rvalid = 0;
    logic [EAW-1:0] ext_addr;
    logic [31:0] ext_rdata = '0;
    logic bank_we, bank_sel, seg_ready, seg_bank, frame_done;
    logic [BAW-1:0] bank_waddr;
    logic [31:0] bank_wdata;
    logic [RW-1:0] seg_row0, seg_nrows;

    always #5 clk = ~clk;

    seg_prefetch #(.IMG_W(IMG_W), .IMG_H(IMG_H), .KER(KER), .SEG_ROWS(SEG_ROWS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .release_seg(release_seg),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_ready(ext_ready),
        .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata), .bank_we(bank_we),
        .bank_sel(bank_sel), .bank_waddr(bank_waddr), .bank_wdata(bank_wdata),
        .seg_ready(seg_ready), .seg_bank(seg_bank), .seg_row0(seg_row0),
        .seg_nrows(seg_nrows), .frame_done(frame_done)
    );

    int vecs = 0, errs = 0;
    int seg_k = 0, glob = 0, req_i = 0, wr_i = 0;
    int ready_cnt = 0, done_cnt = 0, rel_cnt = 0;
    bit mon_on = 0, stall_chk = 0, ended = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [31:0] word_of(int a);
        return 32'hC3000000 ^ (32'(a) * 32'h00010103);
    endfunction

    function automatic int exp_row0();
        return seg_k * STEP;
    endfunction

    function automatic int exp_rows();
        int r = IMG_H - exp_row0();
        return (r < SEG_ROWS) ? r : SEG_ROWS;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // external memory model and monitor
    initial begin : mem_mon
        forever begin
            bit hs;
            int a;
            @(negedge clk);
            hs = ext_req && ext_ready;
            a  = int'(ext_addr);
            if (mon_on) begin
                if (hs) begin
                    // R3 R2: address sequence restarts per segment at row0*WPR
                    check(a == exp_row0() * WPR + req_i, "R3", "ext_addr", a,
                          exp_row0() * WPR + req_i);
                    // R4: no requests beyond the segment length
                    check(req_i < exp_rows() * WPR, "R4", "request count", req_i,
                          exp_rows() * WPR);
                    req_i++;
                end
                if (bank_we) begin
                    // R7
                    check(bank_sel == glob[0], "R7", "bank_sel", int'(bank_sel), glob % 2);
                    // R3
                    check(int'(bank_waddr) == wr_i, "R3", "bank_waddr",
                          int'(bank_waddr), wr_i);
                    check(bank_wdata == word_of(exp_row0() * WPR + wr_i), "R3",
                          "bank_wdata", int'(bank_wdata), int'(word_of(exp_row0() * WPR + wr_i)));
                    wr_i++;
                end
                if (stall_chk) begin
                    // R8
                    check(!ext_req && !bank_we, "R8", "activity while banks held",
                          int'(ext_req), 0);
                end
                if (seg_ready) begin
                    // R6 R5 R4
                    check(int'(seg_bank) == glob % 2, "R6", "seg_bank", int'(seg_bank), glob % 2);
                    check(int'(seg_row0) == exp_row0(), "R5", "seg_row0", int'(seg_row0), exp_row0());
                    check(int'(seg_nrows) == exp_rows(), "R4", "seg_nrows", int'(seg_nrows), exp_rows());
                    check(wr_i == exp_rows() * WPR, "R6", "words before ready", wr_i, exp_rows() * WPR);
                    // R10
                    check(frame_done == (exp_row0() + exp_rows() == IMG_H), "R10", "frame_done",
                          int'(frame_done), int'(exp_row0() + exp_rows() == IMG_H));
                    ready_cnt++;
                    glob++;
                    req_i = 0;
                    wr_i  = 0;
                    if (frame_done) begin
                        seg_k = 0;
                        done_cnt++;
                    end else begin
                        seg_k++;
                    end
                end else if (frame_done) begin
                    check(1'b0, "R10", "frame_done without seg_ready", 1, 0);
                end
            end
            @(posedge clk);
            #1;
            lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ext_ready  = lfsr[0] | lfsr[3];
            ext_rvalid = hs;
            ext_rdata  = hs ? word_of(a) : 32'h0;
        end
    end

    task automatic pulse_rel();
        release_seg = 1;
        @(posedge clk); #1;
        release_seg = 0;
    endtask

    task automatic run_until_done(int target);
        while (done_cnt < target) begin
            if (rel_cnt < ready_cnt) begin
                repeat (3) @(posedge clk);
                #1;
                pulse_rel();
                rel_cnt++;
            end else begin
                @(posedge clk); #1;
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!ended) begin
            errs++;
            $display("FAIL R10 watchdog expired: actual frames %0d expected 2", done_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1
        check(!ext_req && !bank_we && !seg_ready && !frame_done, "R1", "reset outputs",
              int'(ext_req) + int'(bank_we) + int'(seg_ready) + int'(frame_done), 0);
        @(posedge clk); #1;
        rst_n  = 1;
        mon_on = 1;
        repeat (2) @(posedge clk); #1;
        // R9: release with nothing held must be ignored
        pulse_rel();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!ext_req, "R2", "request before start", int'(ext_req), 0);
        @(posedge clk); #1;
        start = 1;
        @(posedge clk); #1;
        start = 0;
        repeat (4) @(posedge clk); #1;
        // R2: start during a frame ignored (monitor verifies addresses)
        start = 1;
        @(posedge clk); #1;
        start = 0;
        while (ready_cnt < 2) begin
            @(posedge clk); #1;
        end
        repeat (2) @(posedge clk); #1;
        stall_chk = 1;
        repeat (25) @(posedge clk); #1;
        stall_chk = 0;
        // R9: the first release frees bank 0, fill resumes there (R7 checked by monitor)
        run_until_done(1);
        repeat (3) @(posedge clk); #1;
        start = 1;
        @(posedge clk); #1;
        start = 0;
        run_until_done(2);
        while (rel_cnt < ready_cnt) begin
            pulse_rel();
            rel_cnt++;
        end
        repeat (10) @(posedge clk);
        @(negedge clk);
        // R10: back to idle after the frame
        check(!ext_req && !bank_we && !seg_ready, "R10", "idle after frame",
              int'(ext_req) + int'(bank_we), 0);
        check(glob == 10, "R7", "segments in two frames", glob, 10);
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule